// File: doc/BRIEF.md
# Keyed I/O Window Unlock Decoder

This block sits on an 8-bit I/O bus with a 16-bit address. It keeps an adapter's 16-address register window switched off until software writes a fixed five-byte key. The first key byte goes to a key port at 0x779, and the other four go in order to a data port at 0x379. The next write to the data port is then taken as a configuration byte. That byte enables or disables the window, picks its base from an eight-entry table and assigns an interrupt line. After the configuration byte the key matcher is idle again, so each reconfiguration needs a fresh key.

A parameter chooses which of two key sets is used. Set 0 is 0x59 B9 C5 AE A6 and set 1 is 0x0F 22 F0 20 80. A second parameter chooses which of two base tables is used. Table 0 holds 0x280 290 300 310 330 340 348 350 and table 1 holds 0x220 240 280 2A0 2C0 300 320 340, both listed by index 0 to 7.

The outputs are a window select, the current base and the current interrupt number, which go to the adapter core behind the window. A single control register at window offset 9 keeps only its top bit. Software uses it to confirm that the window has come alive.

Top module: `io_window_unlock`

## Requirements
- R1: After reset the window is disabled, the interrupt number is 0, the base output is table entry 0, the matcher is idle, and every read returns 0xFF.
- R2: The window is enabled only by a configuration byte that follows the full key. That is key byte 0 written to 0x779, then key bytes 1 to 4 written in order to 0x379, then the configuration byte written to 0x379. In the configuration byte, bit 7 is the enable, bits 2:0 are the table index and bits 6:4 are the interrupt number. Base and interrupt change only on such a write.
- R3: An interrupt field of 2, 3, 4, 5 or 7 is output unchanged. Any other value gives 0.
- R4: A data-port write whose byte is not the expected key byte sends the matcher back to idle, and the configuration byte that follows has no effect.
- R5: A write to 0x779 in the middle of the key restarts the matcher at step 1 if the byte is key byte 0. Any other byte sends the matcher to idle.
- R6: A configuration byte of 0x00 disables the window. After it, reads at the old base return 0xFF and the base output returns to entry 0.
- R7: When enabled, the window covers base to base+15. Select is high only for a read or write strobe inside that range.
- R8: Window offset 9 holds only bit 7 of what was written, and bits 6:0 read as 0. Writing 0xC0 reads back 0x80.
- R9: Reads outside an enabled window return 0xFF. Reads at window offsets other than 9 return 0x00.
- R10: After a configuration byte the matcher is idle. A further write to 0x379 does not reconfigure the window.
- R11: Accesses to addresses other than 0x779 and 0x379 do not disturb the matcher's progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, 0xFF when not in an enabled window |
| winSel | output | 1 | Access falls inside the enabled window |
| winBase | output | 16 | Base address selected by the table index |
| winIrq | output | 3 | Interrupt number, 0 meaning none |

## Verification
The assertions assume that a read and a write are never strobed in the same cycle. They also assume that each write strobe lasts exactly one cycle, so that every bus write counts as a single key step. The stimulus tasks raise one strobe at a time for a single cycle and drop it before the next access. The window bases in both tables lie far from 0x379 and 0x779, so a window access can never be taken for a key-port write.

// File: rtl/io_unlock_pkg.sv
package io_unlock_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 3;
  localparam int IRQ_W   = 3;
  localparam int KEY_LEN = 5;
  localparam int TAB_N   = 2 ** IDX_W;

  typedef struct packed {
    logic cfgLoad;
    logic ctlWr;
  } ioStrobes_t;

  function automatic logic [DATA_W-1:0] magicByte(input int setSel, input int pos);
    logic [DATA_W-1:0] b;
    if (setSel == 0) begin
      case (pos)
        0: b = 8'h59;
        1: b = 8'hB9;
        2: b = 8'hC5;
        3: b = 8'hAE;
        default: b = 8'hA6;
      endcase
    end else begin
      case (pos)
        0: b = 8'h0F;
        1: b = 8'h22;
        2: b = 8'hF0;
        3: b = 8'h20;
        default: b = 8'h80;
      endcase
    end
    return b;
  endfunction

  function automatic logic [ADDR_W-1:0] baseAddr(input int setSel, input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    if (setSel == 0) begin
      case (idx)
        3'd0: a = 16'h0280;
        3'd1: a = 16'h0290;
        3'd2: a = 16'h0300;
        3'd3: a = 16'h0310;
        3'd4: a = 16'h0330;
        3'd5: a = 16'h0340;
        3'd6: a = 16'h0348;
        default: a = 16'h0350;
      endcase
    end else begin
      case (idx)
        3'd0: a = 16'h0220;
        3'd1: a = 16'h0240;
        3'd2: a = 16'h0280;
        3'd3: a = 16'h02A0;
        3'd4: a = 16'h02C0;
        3'd5: a = 16'h0300;
        3'd6: a = 16'h0320;
        default: a = 16'h0340;
      endcase
    end
    return a;
  endfunction

  function automatic logic [IRQ_W-1:0] irqLegal(input logic [IRQ_W-1:0] v);
    case (v)
      3'd2, 3'd3, 3'd4, 3'd5, 3'd7: return v;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/io_unlock_ctrl.sv
module io_unlock_ctrl
  import io_unlock_pkg::*;
#(
  parameter int MAGIC_SET  = 0,
  parameter logic [15:0] KEY_PORT  = 16'h0779,
  parameter logic [15:0] DATA_PORT = 16'h0379,
  parameter int WIN_SPAN   = 16,
  parameter int CTL_OFFSET = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              winHit,
  input  logic [$clog2(WIN_SPAN)-1:0] winOff,
  output ioStrobes_t        strobes
);

  localparam int STEP_W = $clog2(KEY_LEN + 1);
  localparam int OFF_W  = $clog2(WIN_SPAN);

  logic [STEP_W-1:0] step, nextStep;
  logic keyHit, dataHit, loadNow;

  assign keyHit  = ioWr && (ioAddr == KEY_PORT);
  assign dataHit = ioWr && (ioAddr == DATA_PORT);

  // Key matcher: step counts matched key bytes; KEY_LEN means "await config".
  always_comb begin
    nextStep = step;
    loadNow  = 1'b0;
    if (keyHit) begin
      nextStep = (ioWrData == magicByte(MAGIC_SET, 0)) ? STEP_W'(1) : '0;
    end else if (dataHit) begin
      if (step == STEP_W'(KEY_LEN)) begin
        loadNow  = 1'b1;
        nextStep = '0;
      end else if (step != '0) begin
        nextStep = (ioWrData == magicByte(MAGIC_SET, int'(step))) ? step + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) step <= '0;
    else       step <= nextStep;
  end

  always_comb begin
    strobes.cfgLoad = loadNow;
    strobes.ctlWr   = ioWr && winHit && (winOff == OFF_W'(CTL_OFFSET));
  end

endmodule

// File: rtl/io_unlock_dp.sv
module io_unlock_dp
  import io_unlock_pkg::*;
#(
  parameter int BASE_SET   = 0,
  parameter int WIN_SPAN   = 16,
  parameter int CTL_OFFSET = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strobes,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWrData,
  output logic              winHit,
  output logic [$clog2(WIN_SPAN)-1:0] winOff,
  output logic [DATA_W-1:0] ioRdData,
  output logic              winSel,
  output logic [ADDR_W-1:0] winBase,
  output logic [IRQ_W-1:0]  winIrq
);

  localparam int OFF_W = $clog2(WIN_SPAN);

  logic              enReg;
  logic [IDX_W-1:0]  idxReg;
  logic [IRQ_W-1:0]  irqReg;
  logic              ctlBit;
  logic [ADDR_W-1:0] baseTab [TAB_N];
  logic [ADDR_W-1:0] delta;

  for (genvar g = 0; g < TAB_N; g++) begin : g_base
    assign baseTab[g] = baseAddr(BASE_SET, IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      idxReg <= '0;
      irqReg <= '0;
      ctlBit <= 1'b0;
    end else begin
      if (strobes.cfgLoad) begin
        enReg  <= ioWrData[7];
        idxReg <= ioWrData[IDX_W-1:0];
        irqReg <= irqLegal(ioWrData[6:4]);
      end
      if (strobes.ctlWr) ctlBit <= ioWrData[7];
    end
  end

  assign winBase = baseTab[idxReg];
  assign winIrq  = irqReg;
  assign delta   = ioAddr - winBase;
  assign winHit  = enReg && (ioAddr >= winBase) && (delta < ADDR_W'(WIN_SPAN));
  assign winOff  = delta[OFF_W-1:0];
  assign winSel  = winHit && (ioRd || ioWr);

  always_comb begin
    if (winHit && ioRd)
      ioRdData = (winOff == OFF_W'(CTL_OFFSET)) ? {ctlBit, 7'b0} : 8'h00;
    else
      ioRdData = 8'hFF;
  end

endmodule

// File: rtl/io_window_unlock.sv
module io_window_unlock
  import io_unlock_pkg::*;
#(
  parameter int MAGIC_SET  = 0,
  parameter int BASE_SET   = 0,
  parameter logic [15:0] KEY_PORT  = 16'h0779,
  parameter logic [15:0] DATA_PORT = 16'h0379,
  parameter int WIN_SPAN   = 16,
  parameter int CTL_OFFSET = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic        ioWr,
  input  logic        ioRd,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  output logic        winSel,
  output logic [15:0] winBase,
  output logic [2:0]  winIrq
);

  localparam int OFF_W = $clog2(WIN_SPAN);

  ioStrobes_t        strobes;
  logic              winHit;
  logic [OFF_W-1:0]  winOff;

  io_unlock_ctrl #(
    .MAGIC_SET(MAGIC_SET), .KEY_PORT(KEY_PORT), .DATA_PORT(DATA_PORT),
    .WIN_SPAN(WIN_SPAN), .CTL_OFFSET(CTL_OFFSET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioWrData(ioWrData),
    .winHit(winHit), .winOff(winOff), .strobes(strobes)
  );

  io_unlock_dp #(
    .BASE_SET(BASE_SET), .WIN_SPAN(WIN_SPAN), .CTL_OFFSET(CTL_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ioAddr(ioAddr), .ioWr(ioWr),
    .ioRd(ioRd), .ioWrData(ioWrData), .winHit(winHit), .winOff(winOff),
    .ioRdData(ioRdData), .winSel(winSel), .winBase(winBase), .winIrq(winIrq)
  );

endmodule

// File: rtl/io_window_unlock_chk.sv
module io_window_unlock_chk #(
  parameter logic [15:0] DATA_PORT = 16'h0379,
  parameter int WIN_SPAN   = 16,
  parameter int CTL_OFFSET = 9
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] ioAddr,
  input logic        ioWr,
  input logic        ioRd,
  input logic [7:0]  ioWrData,
  input logic [7:0]  ioRdData,
  input logic        winSel,
  input logic [15:0] winBase,
  input logic [2:0]  winIrq,
  input logic        cfgLoad
);

  // R2: base and interrupt move only after a configuration load
  a_r2_cfg_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> ($stable(winBase) && $stable(winIrq)));

  // R3: interrupt output is always a legal line or 0
  a_r3_irq_legal: assert property (@(posedge clk) disable iff (!rstN)
    (winIrq == 3'd0 || winIrq == 3'd2 || winIrq == 3'd3 ||
     winIrq == 3'd4 || winIrq == 3'd5 || winIrq == 3'd7));

  // R4: a configuration load only ever comes from a data-port write
  a_r4_load_at_data_port: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |-> (ioWr && ioAddr == DATA_PORT));

  // R6: a zero configuration byte leaves no window selectable
  a_r6_zero_disables: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && ioWrData == 8'h00) |=> !winSel);

  // R7: select stays inside the 16-address span
  a_r7_sel_in_span: assert property (@(posedge clk) disable iff (!rstN)
    winSel |-> (ioAddr >= winBase && {1'b0, ioAddr} < ({1'b0, winBase} + 17'(WIN_SPAN))));

  // R8: the control register never returns its low bits
  a_r8_ctl_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && winSel && ioAddr == winBase + 16'(CTL_OFFSET)) |-> (ioRdData[6:0] == 7'd0));

endmodule

bind io_window_unlock io_window_unlock_chk #(
  .DATA_PORT(DATA_PORT), .WIN_SPAN(WIN_SPAN), .CTL_OFFSET(CTL_OFFSET)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .winSel(winSel),
  .winBase(winBase), .winIrq(winIrq), .cfgLoad(strobes.cfgLoad)
);

// File: tb/io_window_unlock_bench.sv
module io_window_unlock_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWrData = 8'h0;
  logic [7:0]  ioRdData;
  logic        winSel;
  logic [15:0] winBase;
  logic [2:0]  winIrq;

  int total = 0;
  int bad = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  io_window_unlock u_io_window_unlock (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .winSel(winSel),
    .winBase(winBase), .winIrq(winIrq)
  );

  // Behavioural reference state
  int keyT [5] = '{8'h59, 8'hB9, 8'hC5, 8'hAE, 8'hA6};
  int baseT [8] = '{16'h280, 16'h290, 16'h300, 16'h310, 16'h330, 16'h340, 16'h348, 16'h350};
  int mStep = 0, mIdx = 0, mIrq = 0;
  bit mEn = 0, mCtl = 0;

  function automatic bit inWin(int a);
    return mEn && a >= baseT[mIdx] && a < baseT[mIdx] + 16;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStep = 0; mEn = 0; mIdx = 0; mIrq = 0; mCtl = 0;
    end else if (ioWr) begin
      int a, d, iv;
      a = ioAddr; d = ioWrData;
      if (a == 16'h779) begin
        mStep = (d == keyT[0]) ? 1 : 0;
      end else if (a == 16'h379) begin
        if (mStep == 5) begin
          mEn = d[7]; mIdx = d & 7; iv = (d >> 4) & 7;
          mIrq = (iv == 2 || iv == 3 || iv == 4 || iv == 5 || iv == 7) ? iv : 0;
          mStep = 0;
        end else if (mStep > 0) begin
          mStep = (d == keyT[mStep]) ? mStep + 1 : 0;
        end
      end else if (inWin(a) && (a - baseT[mIdx]) == 9) begin
        mCtl = d[7];
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      int a, expRd;
      bit expSel;
      a = ioAddr;
      expSel = inWin(a) && (ioRd || ioWr);
      if (inWin(a) && ioRd) expRd = ((a - baseT[mIdx]) == 9) ? (mCtl ? 8'h80 : 8'h00) : 8'h00;
      else expRd = 8'hFF;
      total++;
      if (winSel !== expSel || winBase !== 16'(baseT[mIdx]) || winIrq !== 3'(mIrq) || ioRdData !== 8'(expRd)) begin
        bad++;
        $display("FAIL %s model: actual sel=%0b base=%h irq=%0d rd=%h expected sel=%0b base=%h irq=%0d rd=%h",
                 phase, winSel, winBase, winIrq, ioRdData, expSel, baseT[mIdx], mIrq, expRd);
      end
    end
  end

  task automatic wrIo(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    ioAddr = a; ioWrData = d; ioWr = 1'b1; ioRd = 1'b0;
    @(negedge clk); #2;
    ioWr = 1'b0;
  endtask

  task automatic sendKey();
    wrIo(16'h779, 8'h59);
    wrIo(16'h379, 8'hB9);
    wrIo(16'h379, 8'hC5);
    wrIo(16'h379, 8'hAE);
    wrIo(16'h379, 8'hA6);
  endtask

  task automatic checkRead(input logic [15:0] a, input logic [7:0] expD, input logic expS, input string tag);
    @(negedge clk); #2;
    ioAddr = a; ioRd = 1'b1; ioWr = 1'b0;
    #5;
    total++;
    if (ioRdData !== expD || winSel !== expS) begin
      bad++;
      $display("FAIL %s read %h: actual data=%h sel=%0b expected data=%h sel=%0b", tag, a, ioRdData, winSel, expD, expS);
    end
    @(negedge clk); #2;
    ioRd = 1'b0;
  endtask

  task automatic checkOut(input logic [15:0] expB, input logic [2:0] expI, input string tag);
    @(negedge clk); #5;
    total++;
    if (winBase !== expB || winIrq !== expI) begin
      bad++;
      $display("FAIL %s outputs: actual base=%h irq=%0d expected base=%h irq=%0d", tag, winBase, winIrq, expB, expI);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    phase = "R1";
    checkOut(16'h0280, 3'd0, "R1");
    checkRead(16'h0280, 8'hFF, 1'b0, "R1");
    wrIo(16'h0379, 8'h80); // no key: ignored
    checkRead(16'h0280, 8'hFF, 1'b0, "R1");

    phase = "R2";
    sendKey();
    wrIo(16'h0379, 8'hD2); // enable, idx 2, irq 5
    checkOut(16'h0300, 3'd5, "R2");
    checkRead(16'h0300, 8'h00, 1'b1, "R2");

    phase = "R8";
    wrIo(16'h0309, 8'hC0);
    checkRead(16'h0309, 8'h80, 1'b1, "R8");

    phase = "R9";
    checkRead(16'h0303, 8'h00, 1'b1, "R9");
    checkRead(16'h0280, 8'hFF, 1'b0, "R9");

    phase = "R7";
    checkRead(16'h030F, 8'h00, 1'b1, "R7");
    checkRead(16'h0310, 8'hFF, 1'b0, "R7");
    checkRead(16'h02FF, 8'hFF, 1'b0, "R7");

    phase = "R3";
    sendKey();
    wrIo(16'h0379, 8'hE0); // irq 6 -> 0, idx 0
    checkOut(16'h0280, 3'd0, "R3");
    sendKey();
    wrIo(16'h0379, 8'hF1); // irq 7, idx 1
    checkOut(16'h0290, 3'd7, "R3");
    sendKey();
    wrIo(16'h0379, 8'h96); // irq 1 -> 0, idx 6
    checkOut(16'h0348, 3'd0, "R3");
    sendKey();
    wrIo(16'h0379, 8'hA1); // irq 2, idx 1
    checkOut(16'h0290, 3'd2, "R3");

    phase = "R10";
    wrIo(16'h0379, 8'h00);
    checkRead(16'h0290, 8'h00, 1'b1, "R10");
    checkOut(16'h0290, 3'd2, "R10");

    phase = "R4";
    wrIo(16'h0779, 8'h59);
    wrIo(16'h0379, 8'hB9);
    wrIo(16'h0379, 8'hC4); // wrong
    wrIo(16'h0379, 8'hAE);
    wrIo(16'h0379, 8'hA6);
    wrIo(16'h0379, 8'h00);
    checkRead(16'h0290, 8'h00, 1'b1, "R4");

    phase = "R5";
    wrIo(16'h0779, 8'h59);
    wrIo(16'h0379, 8'hB9);
    wrIo(16'h0779, 8'h12); // non-key byte -> idle
    wrIo(16'h0379, 8'hC5);
    wrIo(16'h0379, 8'hAE);
    wrIo(16'h0379, 8'hA6);
    wrIo(16'h0379, 8'h00);
    checkRead(16'h0290, 8'h00, 1'b1, "R5");
    wrIo(16'h0779, 8'h59);
    wrIo(16'h0379, 8'hB9);
    wrIo(16'h0379, 8'hC5);
    wrIo(16'h0779, 8'h59); // restart at step 1
    wrIo(16'h0379, 8'hB9);
    wrIo(16'h0379, 8'hC5);
    wrIo(16'h0379, 8'hAE);
    wrIo(16'h0379, 8'hA6);
    wrIo(16'h0379, 8'hB3); // enable, idx 3, irq 3
    checkOut(16'h0310, 3'd3, "R5");
    checkRead(16'h0310, 8'h00, 1'b1, "R5");

    phase = "R11";
    wrIo(16'h0779, 8'h59);
    wrIo(16'h0379, 8'hB9);
    wrIo(16'h0200, 8'h33);
    checkRead(16'h0312, 8'h00, 1'b1, "R11");
    wrIo(16'h0379, 8'hC5);
    wrIo(16'h0379, 8'hAE);
    wrIo(16'h0379, 8'hA6);
    wrIo(16'h0379, 8'hC7); // enable, idx 7, irq 4
    checkOut(16'h0350, 3'd4, "R11");

    phase = "R6";
    sendKey();
    wrIo(16'h0379, 8'h00);
    checkOut(16'h0280, 3'd0, "R6");
    checkRead(16'h0350, 8'hFF, 1'b0, "R6");
    checkRead(16'h0280, 8'hFF, 1'b0, "R6");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule